// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries out a processor core's hardware reaction to an interrupt, and the matching return. At an instruction boundary, with a request pending and the enable flag set, it acknowledges the request and pulses the vector back to the requester. It then writes the interrupted context to the stack through a single memory port and fetches the handler descriptor from a table in memory. At the end it hands the core a complete new context: the handler address, the original segment values, the flags with interrupts disabled, and the lowered stack pointer.

A return request reverses the frame. The five saved words are read back from the current stack pointer upwards and presented as the restored context, with the enable flag restored as it was saved. The core holds fetch while `busy` is high and takes the new context on the cycle `ctx_load` is high. Every memory access is a request held until the memory acknowledges it, so wait states stretch the sequence without changing it.

Top module: `irq_seq_top`

## Requirements
- R1: An interrupt is accepted only in a cycle where `insn_boundary`, `irq_pending` and bit IF_BIT (default 9) of `cur_flags` are all high and no sequence is in progress. In that cycle `irq_ack` is high for one cycle and `irq_ack_vector` equals `irq_vector`.
- R2: After acceptance the block issues five writes (`mem_we`=1) at S-8, S-16, S-24, S-32 and S-40, where S is `cur_sp` at acceptance. The data written is, in that order, the program counter, code segment, flags, stack pointer S and stack segment.
- R3: After the pushes the block issues two reads at T+V*16 and T+V*16+8, where T is `idt_base` and V is the accepted vector.
- R4: On the entry's `ctx_load` cycle, `new_pc` equals the data of the first descriptor read, `new_sp` equals S-40, and `new_cs` and `new_ss` equal the saved values. `new_flags` equals the saved flags with bit IF_BIT cleared.
- R5: `busy` is high from the accepting cycle up to and including the `ctx_load` cycle, and low in the cycle after it.
- R6: While `mem_req` is high and `mem_ack` is low, the request, address, direction and write data hold steady into the next cycle.
- R7: A request still pending during a sequence is not acknowledged before that sequence's `ctx_load`.
- R8: A return request (`iret_req`) with the block idle starts five reads at P, P+8, P+16, P+24 and P+32, where P is `cur_sp`. On its `ctx_load` cycle these reads appear as `new_ss`, `new_sp`, `new_flags`, `new_cs` and `new_pc` respectively, so an entry followed by a return restores all five values exactly, the enable flag included.
- R9: When `iret_req` and an acceptable interrupt are present in the same idle cycle, the return wins and `irq_ack` stays low.
- R10: The pushed context is taken from the inputs in the accepting cycle. Changes to the `cur_*` inputs later in the sequence do not alter the written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_boundary | input | 1 | Current instruction is completing this cycle |
| irq_pending | input | 1 | Interrupt request waiting |
| irq_vector | input | VEC_W | Vector number of the waiting request |
| irq_ack | output | 1 | One-cycle acknowledge of an accepted request |
| irq_ack_vector | output | VEC_W | Vector being acknowledged |
| iret_req | input | 1 | Core requests a return from interrupt |
| cur_pc | input | DW | Core program counter |
| cur_cs | input | DW | Core code segment |
| cur_flags | input | DW | Core flags |
| cur_sp | input | DW | Core stack pointer |
| cur_ss | input | DW | Core stack segment |
| idt_base | input | AW | Descriptor table base address |
| busy | output | 1 | Core must stall fetch |
| ctx_load | output | 1 | New context valid, core loads it this cycle |
| new_pc | output | DW | Program counter to load |
| new_cs | output | DW | Code segment to load |
| new_flags | output | DW | Flags to load |
| new_sp | output | DW | Stack pointer to load |
| new_ss | output | DW | Stack segment to load |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| mem_ack | input | 1 | Memory completes the request this cycle |

## Verification
The bench builds the block with its defaults: a 64-bit word and address, an 8-bit vector and the enable flag at bit 9. With 8-byte words the frame is 40 bytes and each descriptor 16, so the bench can check every push and pop address exactly. With an 8-bit vector, vector 255 over a nonzero table base is in reach, and it shows that the vector is scaled without truncation. The bench's memory model adds zero to three wait states per run, which exercises the held-request rule and shows that the ordering does not depend on latency.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PUSH = 3'd1,
    ST_DESC = 3'd2,
    ST_POP  = 3'd3,
    ST_LOAD = 3'd4
  } seq_state_e;

  // Slot order is the push order: pc, cs, flags, sp, ss.
  localparam int CTX_SLOTS  = 5;
  localparam int DESC_WORDS = 2;
endpackage

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int SLOTS  = CTX_SLOTS,
  parameter int DWORDS = DESC_WORDS,
  parameter int STEP_W = $clog2(CTX_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_entry,
  input  logic              start_ret,
  input  logic              mem_ack,
  output seq_state_e        state,
  output logic [STEP_W-1:0] step,
  output logic              is_ret
);
  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              ret_q, ret_d;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    ret_d   = ret_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ret) begin
          state_d = ST_POP;
          step_d  = '0;
          ret_d   = 1'b1;
        end else if (start_entry) begin
          state_d = ST_PUSH;
          step_d  = '0;
          ret_d   = 1'b0;
        end
      end
      ST_PUSH: if (mem_ack) begin
        if (step_q == STEP_W'(SLOTS-1)) begin
          state_d = ST_DESC;
          step_d  = '0;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      ST_DESC: if (mem_ack) begin
        if (step_q == STEP_W'(DWORDS-1)) begin
          state_d = ST_LOAD;
          step_d  = '0;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      ST_POP: if (mem_ack) begin
        if (step_q == STEP_W'(SLOTS-1)) begin
          state_d = ST_LOAD;
          step_d  = '0;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      ST_LOAD: begin
        state_d = ST_IDLE;
        step_d  = '0;
      end
      default: begin
        state_d = ST_IDLE;
        step_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      ret_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      ret_q   <= ret_d;
    end
  end

  assign state  = state_q;
  assign step   = step_q;
  assign is_ret = ret_q;
endmodule

// File: rtl/irq_seq_addr.sv
module irq_seq_addr
  import irq_seq_pkg::*;
#(
  parameter int AW     = 64,
  parameter int DW     = 64,
  parameter int VEC_W  = 8,
  parameter int STEP_W = 3
) (
  input  seq_state_e        state,
  input  logic [STEP_W-1:0] step,
  input  logic [AW-1:0]     sp_base,
  input  logic [AW-1:0]     tbl_base,
  input  logic [VEC_W-1:0]  vector,
  output logic [AW-1:0]     addr
);
  localparam int WB  = DW / 8;
  localparam int DSH = $clog2(DESC_WORDS * WB);

  logic [AW-1:0] step_off, push_off, desc_base;

  assign step_off  = AW'(step) * AW'(WB);
  assign push_off  = step_off + AW'(WB);
  assign desc_base = tbl_base + (AW'(vector) << DSH);

  always_comb begin
    unique case (state)
      ST_PUSH: addr = sp_base - push_off;
      ST_DESC: addr = desc_base + step_off;
      ST_POP:  addr = sp_base + step_off;
      default: addr = sp_base;
    endcase
  end
endmodule

// File: rtl/irq_seq_ctx.sv
module irq_seq_ctx #(
  parameter int DW     = 64,
  parameter int SLOTS  = 5,
  parameter int STEP_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       snap_en,
  input  logic [SLOTS-1:0][DW-1:0]   snap_in,
  input  logic                       pop_en,
  input  logic [STEP_W-1:0]          pop_step,
  input  logic [DW-1:0]              rd_data,
  input  logic                       hnd_en,
  output logic [SLOTS-1:0][DW-1:0]   ctx,
  output logic [DW-1:0]              handler
);
  logic [DW-1:0] ctx_q [SLOTS];
  logic [DW-1:0] hnd_q;

  // Pops run from the last slot back to the first.
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic pop_hit;
    assign pop_hit = pop_en && (pop_step == STEP_W'(SLOTS-1-g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctx_q[g] <= '0;
      end else if (snap_en) begin
        ctx_q[g] <= snap_in[g];
      end else if (pop_hit) begin
        ctx_q[g] <= rd_data;
      end
    end
    assign ctx[g] = ctx_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hnd_q <= '0;
    end else if (hnd_en) begin
      hnd_q <= rd_data;
    end
  end

  assign handler = hnd_q;
endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top
  import irq_seq_pkg::*;
#(
  parameter int DW     = 64,
  parameter int AW     = 64,
  parameter int VEC_W  = 8,
  parameter int IF_BIT = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_boundary,
  input  logic             irq_pending,
  input  logic [VEC_W-1:0] irq_vector,
  output logic             irq_ack,
  output logic [VEC_W-1:0] irq_ack_vector,
  input  logic             iret_req,
  input  logic [DW-1:0]    cur_pc,
  input  logic [DW-1:0]    cur_cs,
  input  logic [DW-1:0]    cur_flags,
  input  logic [DW-1:0]    cur_sp,
  input  logic [DW-1:0]    cur_ss,
  input  logic [AW-1:0]    idt_base,
  output logic             busy,
  output logic             ctx_load,
  output logic [DW-1:0]    new_pc,
  output logic [DW-1:0]    new_cs,
  output logic [DW-1:0]    new_flags,
  output logic [DW-1:0]    new_sp,
  output logic [DW-1:0]    new_ss,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_ack
);
  localparam int WB          = DW / 8;
  localparam int STEP_W      = $clog2(CTX_SLOTS);
  localparam int FRAME_BYTES = CTX_SLOTS * WB;

  seq_state_e                   state;
  logic [STEP_W-1:0]            step;
  logic                         is_ret;
  logic                         idle, take_irq, take_ret;
  logic [DW-1:0]                base_q;
  logic [VEC_W-1:0]             vec_q;
  logic [CTX_SLOTS-1:0][DW-1:0] snap_in, ctx;
  logic [DW-1:0]                handler;
  logic                         pop_en, hnd_en;

  assign idle     = (state == ST_IDLE);
  assign take_ret = idle && iret_req;
  assign take_irq = idle && !iret_req && insn_boundary && irq_pending && cur_flags[IF_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      vec_q  <= '0;
    end else begin
      if (take_irq || take_ret) base_q <= cur_sp;
      if (take_irq)             vec_q  <= irq_vector;
    end
  end

  assign snap_in[0] = cur_pc;
  assign snap_in[1] = cur_cs;
  assign snap_in[2] = cur_flags;
  assign snap_in[3] = cur_sp;
  assign snap_in[4] = cur_ss;

  irq_seq_fsm #(
    .SLOTS(CTX_SLOTS), .DWORDS(DESC_WORDS), .STEP_W(STEP_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_entry(take_irq), .start_ret(take_ret),
    .mem_ack(mem_ack), .state(state), .step(step), .is_ret(is_ret)
  );

  irq_seq_addr #(
    .AW(AW), .DW(DW), .VEC_W(VEC_W), .STEP_W(STEP_W)
  ) u_addr (
    .state(state), .step(step), .sp_base(AW'(base_q)), .tbl_base(idt_base),
    .vector(vec_q), .addr(mem_addr)
  );

  assign pop_en = (state == ST_POP) && mem_ack;
  assign hnd_en = (state == ST_DESC) && mem_ack && (step == '0);

  irq_seq_ctx #(
    .DW(DW), .SLOTS(CTX_SLOTS), .STEP_W(STEP_W)
  ) u_ctx (
    .clk(clk), .rst_n(rst_n), .snap_en(take_irq), .snap_in(snap_in),
    .pop_en(pop_en), .pop_step(step), .rd_data(mem_rdata), .hnd_en(hnd_en),
    .ctx(ctx), .handler(handler)
  );

  always_comb begin
    mem_wdata = '0;
    if (state == ST_PUSH) begin
      for (int k = 0; k < CTX_SLOTS; k++) begin
        if (step == STEP_W'(k)) mem_wdata = ctx[k];
      end
    end
  end

  assign mem_req = (state == ST_PUSH) || (state == ST_DESC) || (state == ST_POP);
  assign mem_we  = (state == ST_PUSH);

  assign irq_ack        = take_irq;
  assign irq_ack_vector = irq_vector;
  assign busy           = !idle || take_irq || take_ret;
  assign ctx_load       = (state == ST_LOAD);

  assign new_pc    = is_ret ? ctx[0] : handler;
  assign new_cs    = ctx[1];
  assign new_flags = is_ret ? ctx[2] : (ctx[2] & ~(DW'(1) << IF_BIT));
  assign new_sp    = is_ret ? ctx[3] : (base_q - DW'(FRAME_BYTES));
  assign new_ss    = ctx[4];
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int DW     = 64,
  parameter int AW     = 64,
  parameter int IF_BIT = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          insn_boundary,
  input logic          irq_pending,
  input logic [DW-1:0] cur_flags,
  input logic          iret_req,
  input logic          irq_ack,
  input logic          busy,
  input logic          ctx_load,
  input logic [DW-1:0] new_flags,
  input logic          is_ret,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata
);
  p_accept_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (insn_boundary && irq_pending && cur_flags[IF_BIT]));

  p_if_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_load && !is_ret) |-> !new_flags[IF_BIT]);

  p_busy_on_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> busy);

  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ctx_load) |=> busy);

  p_quiet_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_load |=> !mem_req);

  p_req_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_req_in_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  p_single_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  p_ret_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> !iret_req);
endmodule

bind irq_seq_top irq_seq_chk #(.DW(DW), .AW(AW), .IF_BIT(IF_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary), .irq_pending(irq_pending),
  .cur_flags(cur_flags), .iret_req(iret_req), .irq_ack(irq_ack), .busy(busy),
  .ctx_load(ctx_load), .new_flags(new_flags), .is_ret(is_ret), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/irq_seq_top_bench.sv
module irq_seq_top_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, insn_boundary, irq_pending, iret_req;
  logic [7:0]  irq_vector, irq_ack_vector;
  logic        irq_ack, busy, ctx_load;
  logic [63:0] cur_pc, cur_cs, cur_flags, cur_sp, cur_ss, idt_base;
  logic [63:0] new_pc, new_cs, new_flags, new_sp, new_ss;
  logic        mem_req, mem_we, mem_ack;
  logic [63:0] mem_addr, mem_wdata, mem_rdata;

  irq_seq_top u_irq_seq_top (
    .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary), .irq_pending(irq_pending),
    .irq_vector(irq_vector), .irq_ack(irq_ack), .irq_ack_vector(irq_ack_vector),
    .iret_req(iret_req), .cur_pc(cur_pc), .cur_cs(cur_cs), .cur_flags(cur_flags),
    .cur_sp(cur_sp), .cur_ss(cur_ss), .idt_base(idt_base), .busy(busy),
    .ctx_load(ctx_load), .new_pc(new_pc), .new_cs(new_cs), .new_flags(new_flags),
    .new_sp(new_sp), .new_ss(new_ss), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // Memory model: word index from address bits [10:3], fixed wait states.
  logic [63:0] mem [256];
  int          wait_n, wcnt, log_n, stab_bad;
  logic [63:0] log_addr [64];
  logic [63:0] log_data [64];
  logic        log_we   [64];
  logic        prev_hold;
  logic [63:0] prev_addr;

  assign mem_ack   = mem_req && (wcnt >= wait_n);
  assign mem_rdata = mem[mem_addr[10:3]];

  function automatic logic [63:0] pattern(input logic [63:0] a);
    return 64'hD000_0000_0000_0000 | {56'd0, a[10:3]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= pattern(64'(i) << 3);
      wcnt      <= 0;
      log_n     <= 0;
      stab_bad  <= 0;
      prev_hold <= 1'b0;
      prev_addr <= '0;
    end else begin
      if (prev_hold && (!mem_req || mem_addr != prev_addr)) stab_bad <= stab_bad + 1;
      prev_hold <= mem_req && !mem_ack;
      prev_addr <= mem_addr;
      if (mem_req && !mem_ack) wcnt <= wcnt + 1; else wcnt <= 0;
      if (mem_req && mem_ack) begin
        if (mem_we) mem[mem_addr[10:3]] <= mem_wdata;
        log_addr[log_n % 64] <= mem_addr;
        log_data[log_n % 64] <= mem_wdata;
        log_we[log_n % 64]   <= mem_we;
        log_n <= log_n + 1;
      end
    end
  end

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // vec, table base, sp, pc, flags, wait states
  localparam logic [91:0] TBL [4] = '{
    {8'h20, 16'h0000, 16'h0600, 32'h0040_1000, 16'h0202, 4'd0},
    {8'h05, 16'h0000, 16'h0580, 32'h0040_2468, 16'h0246, 4'd1},
    {8'h31, 16'h0000, 16'h0700, 32'h1234_5678, 16'h0A03, 4'd3},
    {8'hFF, 16'h1000, 16'h06C0, 32'h00AB_CDE0, 16'h0200, 4'd2}
  };

  int acks;
  bit timed_out;
  logic [63:0] ld_pc, ld_cs, ld_fl, ld_sp, ld_ss;

  task automatic wait_load();
    timed_out = 1'b1;
    for (int n = 0; n < 300; n++) begin
      @(negedge clk); #1;
      if (irq_ack) acks++;
      if (ctx_load) begin
        timed_out = 1'b0;
        ld_pc = new_pc; ld_cs = new_cs; ld_fl = new_flags; ld_sp = new_sp; ld_ss = new_ss;
        break;
      end
    end
    if (timed_out) begin
      total++; bad++;
      $display("FAIL R5 act=no_load exp=ctx_load");
    end
  endtask

  task automatic run_case(input int k);
    logic [7:0]  vec;
    logic [63:0] base, sp, pc, fl, cs, ss, daddr, expsp;
    int          st;
    vec  = TBL[k][91:84];
    base = {48'd0, TBL[k][83:68]};
    sp   = {48'd0, TBL[k][67:52]};
    pc   = {32'd0, TBL[k][51:20]};
    fl   = {48'd0, TBL[k][19:4]};
    cs   = 64'h0010 + 64'(k);
    ss   = 64'h0018 + 64'(k);
    daddr = base + (64'(vec) << 4);
    expsp = sp - 64'd40;
    wait_n = int'(TBL[k][3:0]);
    // entry
    @(negedge clk);
    cur_pc = pc; cur_cs = cs; cur_flags = fl; cur_sp = sp; cur_ss = ss;
    idt_base = base; irq_vector = vec; irq_pending = 1'b1; insn_boundary = 1'b1;
    st = log_n;
    #1;
    chk("R1 ack", {63'd0, irq_ack}, 64'd1);
    chk("R1 ack vector", {56'd0, irq_ack_vector}, {56'd0, vec});
    chk("R5 busy at accept", {63'd0, busy}, 64'd1);
    @(negedge clk);
    // R10: scramble the live context; pending stays high (R7)
    cur_pc = ~pc; cur_cs = 64'h77; cur_flags = fl ^ 64'h00C1; cur_sp = 64'h0123; cur_ss = 64'h99;
    irq_vector = vec ^ 8'h0F;
    acks = 0;
    wait_load();
    insn_boundary = 1'b0; irq_pending = 1'b0;
    chk("R7 no ack during sequence", 64'(acks), 64'd0);
    for (int j = 0; j < 5; j++) begin
      logic [63:0] ed;
      case (j)
        0: ed = pc; 1: ed = cs; 2: ed = fl; 3: ed = sp; default: ed = ss;
      endcase
      chk("R2 push addr", log_addr[(st + j) % 64], sp - 64'(8 * (j + 1)));
      chk("R2 R10 push data", log_data[(st + j) % 64] | {63'd0, ~log_we[(st + j) % 64]}, ed);
    end
    chk("R3 desc addr0", log_addr[(st + 5) % 64] | {63'd0, log_we[(st + 5) % 64]}, daddr);
    chk("R3 desc addr1", log_addr[(st + 6) % 64] | {63'd0, log_we[(st + 6) % 64]}, daddr + 64'd8);
    chk("R4 new pc", ld_pc, pattern(daddr));
    chk("R4 new sp", ld_sp, expsp);
    chk("R4 new cs", ld_cs, cs);
    chk("R4 new ss", ld_ss, ss);
    chk("R4 new flags", ld_fl, fl & ~64'h200);
    @(negedge clk); #1;
    chk("R5 busy low after load", {63'd0, busy}, 64'd0);
    // return
    @(negedge clk);
    cur_sp = expsp; cur_pc = 64'h5555; cur_flags = 64'h0; cur_cs = 64'h1; cur_ss = 64'h2;
    iret_req = 1'b1;
    st = log_n;
    #1;
    chk("R8 busy at return", {63'd0, busy}, 64'd1);
    @(negedge clk);
    iret_req = 1'b0;
    wait_load();
    for (int j = 0; j < 5; j++) begin
      chk("R8 pop addr", log_addr[(st + j) % 64] | {63'd0, log_we[(st + j) % 64]}, expsp + 64'(8 * j));
    end
    chk("R8 restored pc", ld_pc, pc);
    chk("R8 restored cs", ld_cs, cs);
    chk("R8 restored flags", ld_fl, fl);
    chk("R8 restored sp", ld_sp, sp);
    chk("R8 restored ss", ld_ss, ss);
    @(negedge clk); #1;
    chk("R5 busy low after return", {63'd0, busy}, 64'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; insn_boundary = 1'b0; irq_pending = 1'b0; iret_req = 1'b0;
    irq_vector = '0; cur_pc = '0; cur_cs = '0; cur_flags = '0; cur_sp = '0; cur_ss = '0;
    idt_base = '0; wait_n = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R5 reset busy", {63'd0, busy}, 64'd0);
    chk("R6 reset mem_req", {63'd0, mem_req}, 64'd0);
    chk("R1 reset irq_ack", {63'd0, irq_ack}, 64'd0);
    chk("R4 reset ctx_load", {63'd0, ctx_load}, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // R1: enable flag clear blocks acceptance
    @(negedge clk);
    cur_flags = 64'h0002; irq_pending = 1'b1; insn_boundary = 1'b1; irq_vector = 8'h10;
    acks = 0;
    for (int n = 0; n < 3; n++) begin
      #1; if (irq_ack) acks++;
      @(negedge clk);
    end
    chk("R1 no ack with IF clear", 64'(acks), 64'd0);
    chk("R1 no memory traffic", {63'd0, mem_req}, 64'd0);
    // R1: not at a boundary
    cur_flags = 64'h0200; insn_boundary = 1'b0;
    acks = 0;
    for (int n = 0; n < 3; n++) begin
      #1; if (irq_ack) acks++;
      @(negedge clk);
    end
    chk("R1 no ack off boundary", 64'(acks), 64'd0);
    chk("R1 busy stays low", {63'd0, busy}, 64'd0);
    irq_pending = 1'b0;

    // Vector table walk: entry then return
    for (int k = 0; k < 4; k++) run_case(k);

    // R9: return and interrupt in the same cycle
    @(negedge clk);
    wait_n = 0;
    cur_sp = 64'h0500; cur_flags = 64'h0200; irq_pending = 1'b1; insn_boundary = 1'b1;
    irq_vector = 8'h07; iret_req = 1'b1;
    begin
      int st9;
      st9 = log_n;
      #1;
      chk("R9 return wins, no ack", {63'd0, irq_ack}, 64'd0);
      @(negedge clk);
      iret_req = 1'b0; irq_pending = 1'b0; insn_boundary = 1'b0;
      acks = 0;
      wait_load();
      chk("R9 first access is a read", {63'd0, log_we[st9 % 64]}, 64'd0);
      chk("R9 first read at stack", log_addr[st9 % 64], 64'h0500);
      chk("R9 no ack afterwards", 64'(acks), 64'd0);
    end

    @(negedge clk);
    chk("R6 request held steady", 64'(stab_bad), 64'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule